// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the row and column strobes of an asynchronous DRAM whenever the memory is being brought up or refreshed. After reset it waits out a power-up pause and then drives a fixed number of dummy row-strobe pulses with the column strobe held high. Once these are done, it raises `init_done`, and from then on a free-running interval timer posts refresh requests into a small pending counter.

Each pending request is served as a column-before-row refresh. The column strobe drops first, the row strobe follows, and both return high together. The memory's own row counter picks the row, so no address, output-enable or write activity is involved. The access controller reports its ownership on `host_busy`, which it must raise in the same cycle it claims the bus. While it is busy, refreshes are postponed and counted. When the count reaches its limit, `host_stall` keeps the controller from starting anything new, so the backlog is served as soon as its current cycle ends.

All pulse lengths come from nanosecond parameters, rounded up to whole clock cycles at `CLK_MHZ`: `ceil(ns * CLK_MHZ / 1000)`. The interval `REF_CYC = floor(REF_INTERVAL_NS * CLK_MHZ / 1000)` and the pause `PAUSE_CYC = PAUSE_US * CLK_MHZ` are derived in the same way.

Top module: `dram_refresh_seq`

## Requirements
- R1: Out of reset, `ras_n` and `cas_n` are high, `init_done` is low, `pend_cnt` is 0 and `host_stall` is high. The first falling edge of `ras_n` appears exactly `PAUSE_CYC` cycles after reset is released, and `cas_n` stays high until then.
- R2: After the pause, exactly `INIT_CYCLES` row-strobe pulses are issued. Each is low for `RAS_CYC` cycles and is followed by `RP_CYC` high cycles, and `cas_n` stays high throughout. `init_done` rises `RP_CYC` cycles after the last pulse ends, and `host_stall` is high while `init_done` is low.
- R3: With the host idle, the first refresh's `cas_n` falls `REF_CYC + 1` cycles after `init_done` rises, and `pend_cnt` reads 1 one cycle earlier. Later refreshes start exactly `REF_CYC` cycles apart, and that phase is kept across postponements.
- R4: In every refresh, `cas_n` falls while `ras_n` is high. `ras_n` falls `CAS_LEAD_CYC` cycles later, stays low for exactly `RAS_CYC` cycles with `cas_n` low, and both strobes rise in the same cycle.
- R5: `bus_own` is high from the cycle `cas_n` falls through the `RP_CYC` precharge cycles after `ras_n` rises, and it drops in the following cycle.
- R6: No refresh starts in a cycle after one in which `host_busy` was high. Each interval tick adds one to `pend_cnt`, which saturates at `MAX_PEND`.
- R7: `host_stall` is high whenever `pend_cnt` equals `MAX_PEND`, and low when initialisation is done, the block does not own the bus, and `pend_cnt` is below the limit.
- R8: When `host_busy` drops, all pending refreshes run one after another, with one idle cycle between them. `pend_cnt` drops by one as each refresh's `cas_n` falls, and ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_busy | input | 1 | Access controller owns the strobe bus in this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| bus_own | output | 1 | Sequencer holds the strobe bus |
| host_stall | output | 1 | Access controller must not start a new cycle |
| init_done | output | 1 | Power-up pause and init pulses are complete |
| pend_cnt | output | $clog2(MAX_PEND+1) | Number of postponed refreshes |

## Verification
Every strobe and status output is a decode of registered state, so each one moves in the cycle after the edge that changes that state. A refresh's `cas_n` falls one edge after the tick that makes `pend_cnt` nonzero, which is `REF_CYC + 1` cycles after `init_done`. The bench samples at the falling clock edge and counts elapsed edges from each observed event. It then compares these counts with `PAUSE_CYC`, `RAS_CYC`, `RP_CYC` and `REF_CYC` worked out from the nanosecond parameters. The busy-window sweep places each window so that exactly k ticks land inside it, for k from 1 to 5. The expected backlog is then `min(k, MAX_PEND)`, and the refresh after the drain must arrive on the original `REF_CYC` grid.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CLK_MHZ         = 125,
  parameter int PAUSE_US        = 200,
  parameter int INIT_CYCLES     = 8,
  parameter int REF_INTERVAL_NS = 15625,
  parameter int RAS_MIN_NS      = 50,
  parameter int RP_MIN_NS       = 30,
  parameter int CAS_LEAD_CYC    = 1,
  parameter int MAX_PEND        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_busy,
  output logic ras_n,
  output logic cas_n,
  output logic bus_own,
  output logic host_stall,
  output logic init_done,
  output logic [$clog2(MAX_PEND+1)-1:0] pend_cnt
);
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int REF_CYC   = REF_INTERVAL_NS * CLK_MHZ / 1000;
  localparam int RAS_CYC   = (RAS_MIN_NS * CLK_MHZ + 999) / 1000;
  localparam int RP_CYC    = (RP_MIN_NS * CLK_MHZ + 999) / 1000;
  localparam int CW = $clog2(PAUSE_CYC + RAS_CYC + RP_CYC + CAS_LEAD_CYC + 1);
  localparam int TW = $clog2(REF_CYC + 1);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  typedef enum logic [2:0] {S_PAUSE, S_ILOW, S_IPRE, S_IDLE, S_LEAD, S_RLOW, S_RPRE} st_t;

  st_t st;
  logic [CW-1:0] cnt, dur;
  logic [TW-1:0] tmr;
  logic [IW-1:0] icnt;
  logic [PW-1:0] pend;
  logic done;

  always_comb begin
    case (st)
      S_PAUSE:      dur = CW'(PAUSE_CYC);
      S_ILOW, S_RLOW: dur = CW'(RAS_CYC);
      S_IPRE, S_RPRE: dur = CW'(RP_CYC);
      S_LEAD:       dur = CW'(CAS_LEAD_CYC);
      default:      dur = CW'(1);
    endcase
  end

  wire last  = cnt == dur - 1'b1;
  wire full  = pend == PW'(MAX_PEND);
  wire tick  = done && tmr == TW'(REF_CYC - 1);
  wire start = st == S_IDLE && pend != '0 && !host_busy;
  wire inc   = tick && (!full || start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_PAUSE;
      cnt  <= '0;
      icnt <= '0;
      done <= 1'b0;
      tmr  <= '0;
      pend <= '0;
    end else begin
      cnt <= (last || st == S_IDLE) ? '0 : cnt + 1'b1;
      tmr <= (!done || tick) ? '0 : tmr + 1'b1;
      if (inc && !start)      pend <= pend + 1'b1;
      else if (!inc && start) pend <= pend - 1'b1;
      case (st)
        S_PAUSE: if (last) st <= S_ILOW;
        S_ILOW:  if (last) st <= S_IPRE;
        S_IPRE:  if (last) begin
          if (icnt == IW'(INIT_CYCLES - 1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            icnt <= icnt + 1'b1;
            st   <= S_ILOW;
          end
        end
        S_IDLE:  if (start) st <= S_LEAD;
        S_LEAD:  if (last) st <= S_RLOW;
        S_RLOW:  if (last) st <= S_RPRE;
        S_RPRE:  if (last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ras_n      = !(st == S_ILOW || st == S_RLOW);
  assign cas_n      = !(st == S_LEAD || st == S_RLOW);
  assign bus_own    = st != S_IDLE;
  assign init_done  = done;
  assign host_stall = !done || bus_own || full;
  assign pend_cnt   = pend;

  logic [CW-1:0] rlen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rlen <= '0;
    else        rlen <= ras_n ? '0 : rlen + 1'b1;

  p_ras_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> rlen == CW'(RAS_CYC));
  p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $fell(ras_n)) |-> (!cas_n && $past(!cas_n)));
  p_init_no_cas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> cas_n);
  p_busy_defers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !$past(host_busy));
  p_pend_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(MAX_PEND));
  p_pend_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !$past(tick)) |-> pend_cnt == $past(pend_cnt) - 1'b1);
endmodule

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
  localparam int MHZ = 125, PUS = 1, NINIT = 8, RINS = 800, RASNS = 50, RPNS = 30, LEAD = 1, MAXP = 3;
  localparam int E_PAUSE = PUS * MHZ;
  localparam int E_REF   = RINS * MHZ / 1000;
  localparam int E_RAS   = (RASNS * MHZ + 999) / 1000;
  localparam int E_RP    = (RPNS * MHZ + 999) / 1000;

  logic clk = 0, rst_n = 0, host_busy = 0;
  logic ras_n, cas_n, bus_own, host_stall, init_done;
  logic [$clog2(MAXP+1)-1:0] pend_cnt;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_seq #(.CLK_MHZ(MHZ), .PAUSE_US(PUS), .INIT_CYCLES(NINIT), .REF_INTERVAL_NS(RINS),
    .RAS_MIN_NS(RASNS), .RP_MIN_NS(RPNS), .CAS_LEAD_CYC(LEAD), .MAX_PEND(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .ras_n(ras_n), .cas_n(cas_n),
    .bus_own(bus_own), .host_stall(host_stall), .init_done(init_done), .pend_cnt(pend_cnt));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_cbr(input string tag);
    int l, h;
    chk(ras_n && bus_own, {tag, " R4 cas before ras / R5 own"}, {ras_n, bus_own}, 3);
    repeat (LEAD) @(negedge clk);
    l = 0;
    while (!ras_n && l < 50) begin
      if (cas_n) chk(0, {tag, " R4 cas low during ras"}, 1, 0);
      l++;
      @(negedge clk);
    end
    chk(l == E_RAS, {tag, " R4 ras low width"}, l, E_RAS);
    chk(cas_n, {tag, " R4 strobes rise together"}, cas_n, 1);
    h = 0;
    while (bus_own && h < 50) begin
      h++;
      @(negedge clk);
    end
    chk(h == E_RP, {tag, " R5 own through precharge"}, h, E_RP);
  endtask

  task automatic wait_cas(input int lim, output int waited);
    waited = 0;
    while (cas_n && waited < lim) begin
      @(negedge clk);
      waited++;
    end
  endtask

  initial begin
    int n, l, h, w, tcas, bad, nd, expd;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && !init_done && pend_cnt == 0 && host_stall,
        "R1 reset state", {ras_n, cas_n, init_done, host_stall}, 13);
    rst_n = 1;
    n = 0; bad = 0;
    while (ras_n && n < 1000) begin
      @(negedge clk);
      n++;
      if (!cas_n) bad++;
    end
    chk(n == E_PAUSE, "R1 pause length", n, E_PAUSE);
    chk(bad == 0, "R1 cas high in pause", bad, 0);
    for (int i = 0; i < NINIT; i++) begin
      l = 0; bad = 0;
      while (!ras_n && l < 50) begin
        if (!cas_n || init_done || !host_stall) bad++;
        l++;
        @(negedge clk);
      end
      chk(l == E_RAS && bad == 0, "R2 init pulse width", l, E_RAS);
      h = 0;
      while (ras_n && !init_done && h < 50) begin
        if (!cas_n || !host_stall) bad++;
        h++;
        @(negedge clk);
      end
      chk(h == E_RP && bad == 0, "R2 init precharge", h, E_RP);
      chk(init_done == (i == NINIT - 1), "R2 init_done timing", init_done, i == NINIT - 1);
    end
    chk(!host_stall && !bus_own, "R7 stall released after init", host_stall, 0);
    n = 0;
    while (cas_n && n < 300) begin
      @(negedge clk);
      n++;
      if (n == E_REF) chk(pend_cnt == 1, "R3 pend after tick", pend_cnt, 1);
    end
    chk(n == E_REF + 1, "R3 first refresh delay", n, E_REF + 1);
    tcas = cyc;
    check_cbr("first");
    for (int r = 0; r < 3; r++) begin
      wait_cas(300, w);
      chk(cyc - tcas == E_REF, "R3 refresh spacing", cyc - tcas, E_REF);
      tcas = cyc;
      check_cbr("periodic");
    end
    for (int k = 1; k <= 5; k++) begin
      expd = (k < MAXP) ? k : MAXP;
      while (cyc < tcas + 20) @(negedge clk);
      host_busy = 1;
      bad = 0;
      while (cyc < tcas + 50 + 100 * k) begin
        @(negedge clk);
        if (!ras_n || !cas_n) bad++;
      end
      chk(bad == 0, "R6 no refresh while busy", bad, 0);
      chk(pend_cnt == expd, "R6 pending count", pend_cnt, expd);
      chk(host_stall == (k >= MAXP), "R7 stall at limit", host_stall, k >= MAXP);
      host_busy = 0;
      nd = 0;
      for (int d = 0; d < expd; d++) begin
        wait_cas(20, w);
        if (!cas_n) begin
          chk(pend_cnt == expd - 1 - d, "R8 pend drops per refresh", pend_cnt, expd - 1 - d);
          nd++;
          check_cbr("drain");
        end
      end
      chk(nd == expd, "R8 drained count", nd, expd);
      chk(pend_cnt == 0, "R8 backlog empty", pend_cnt, 0);
      wait_cas(300, w);
      chk(cyc - tcas == 100 * (k + 1), "R3 phase kept", cyc - tcas, 100 * (k + 1));
      tcas = cyc;
      check_cbr("after");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule